// File: doc/BRIEF.md
# Processor I/O Port with Address-Space Banking

This block is a small parallel port that sits inside the processor's own address space. Two byte locations at the very bottom of memory hold it. Location 0 sets each pin's direction and location 1 holds the pin values. The port has six pins. The lowest three act as memory-configuration lines. Pin 3 carries tape write data, pin 4 senses a tape button, and pin 5 switches a tape motor. The tape hardware itself is outside this block.

A bank decoder sits alongside the port. For every processor access it reports which resource the address reaches: RAM, the BASIC ROM, the KERNAL ROM, the character ROM, the I/O page, or the port itself. It bases the answer on the live levels of the three configuration pins. A configuration pin set as an input follows the external level, and on a board that level is normally held high by a pull-up. Writes that fall on a ROM window are sent to the RAM underneath it.

The read data and the region code are registered. Both reflect the address presented before the clock edge and the port state held before that edge.

Top module: `cpu_port_banker`

## Requirements
- R1: After reset, `pin_oe` is 0x2F, `pin_out` is 0x3F, `cpu_rdata` is 0 and `region` is 0 (RAM).
- R2: A write (`cpu_we`=1) to address 0 loads `cpu_wdata[5:0]` into the direction register, seen on `pin_oe` after that edge. A read of address 0 returns {2'b00, direction} one cycle later.
- R3: A write to address 1 loads `cpu_wdata[5:0]` into the data register, seen on `pin_out` after that edge.
- R4: A read of address 1 returns, one cycle later, the data bit for every pin whose direction bit is 1 and the `pin_in` bit for every pin whose direction bit is 0. Bits 7:6 read 0. Any other address reads 0.
- R5: Each configuration line is the pin level defined in R4: bit 0 enables BASIC (LO), bit 1 enables KERNAL (HI), and bit 2 selects I/O over character ROM (CS).
- R6: Reads in 0xA000–0xBFFF return region 1 (BASIC) when LO and HI are both 1, and region 0 (RAM) otherwise.
- R7: Reads in 0xE000–0xFFFF return region 2 (KERNAL) when HI is 1, and region 0 otherwise.
- R8: Accesses in 0xD000–0xDFFF return region 0 when LO=HI=0. Otherwise they return region 4 (I/O) when CS=1 and region 3 (character ROM) when CS=0.
- R9: Addresses 0 and 1 always return region 5 (port) and never region 0.
- R10: A write that would decode to region 1, 2 or 3 returns region 0 instead. Writes to the I/O page keep region 4.
- R11: Every other address returns region 0. With the reset direction in place, writing 0x37 to address 1 produces the normal map: BASIC, KERNAL and I/O all visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Registered read data of the port locations |
| pin_out | output | 6 | Pin output values (data register) |
| pin_oe | output | 6 | Pin output enables (direction register) |
| pin_in | input | 6 | External pin levels |
| region | output | 3 | Registered region code of the previous access |

## Verification
The checker assertions run on every cycle. They cover:
- the reset direction value;
- the one-cycle arrival of direction and data writes at the pins;
- the port region for the two low addresses;
- the absence of any ROM code on a write;
- the confinement of the BASIC and KERNAL codes to their own address windows.

The full decode table is shown only by the bench sweeps. Each of the eight configurations is set once through output bits and once through input pins. The bench then probes every window boundary with both reads and writes, and checks the mixed read-back of address 1.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;
  typedef enum logic [2:0] {
    RGN_RAM    = 3'd0,
    RGN_BASIC  = 3'd1,
    RGN_KERNAL = 3'd2,
    RGN_CHAR   = 3'd3,
    RGN_IO     = 3'd4,
    RGN_PORT   = 3'd5
  } region_e;

  localparam int unsigned CFG_W  = 3;
  localparam int unsigned CFG_LO = 0;
  localparam int unsigned CFG_HI = 1;
  localparam int unsigned CFG_CS = 2;
endpackage

// File: rtl/port_regfile.sv
module port_regfile #(
  parameter int unsigned PORT_W   = 6,
  parameter logic [5:0]  RST_DIR  = 6'h2F,
  parameter logic [5:0]  RST_DATA = 6'h3F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_dir,
  input  logic              wr_data,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= RST_DIR[PORT_W-1:0];
      data_q <= RST_DATA[PORT_W-1:0];
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_data) data_q <= wdata;
    end
  end

  // Per-pin level: driven value for outputs, external level for inputs.
  for (genvar b = 0; b < PORT_W; b++) begin : g_level
    assign level[b] = dir_q[b] ? data_q[b] : pin_in[b];
  end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import cpu_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output region_e           region
);
  localparam int unsigned TOP3 = 3;
  localparam int unsigned TOP4 = 4;

  logic [TOP3-1:0] hi3;
  logic [TOP4-1:0] hi4;
  logic            is_port;
  logic            lo, hi, cs;
  region_e         raw;

  assign hi3     = addr[ADDR_W-1 -: TOP3];
  assign hi4     = addr[ADDR_W-1 -: TOP4];
  assign is_port = (addr[ADDR_W-1:1] == '0);
  assign lo      = cfg[CFG_LO];
  assign hi      = cfg[CFG_HI];
  assign cs      = cfg[CFG_CS];

  always_comb begin
    raw = RGN_RAM;
    if (is_port) begin
      raw = RGN_PORT;
    end else if (hi3 == 3'b101) begin
      raw = (lo && hi) ? RGN_BASIC : RGN_RAM;
    end else if (hi3 == 3'b111) begin
      raw = hi ? RGN_KERNAL : RGN_RAM;
    end else if (hi4 == 4'hD) begin
      if (!lo && !hi) raw = RGN_RAM;
      else            raw = cs ? RGN_IO : RGN_CHAR;
    end
  end

  // ROM windows are read-only: stores land in the RAM underneath.
  always_comb begin
    region = raw;
    if (we && (raw == RGN_BASIC || raw == RGN_KERNAL || raw == RGN_CHAR))
      region = RGN_RAM;
  end
endmodule

// File: rtl/cpu_port_banker.sv
module cpu_port_banker
  import cpu_port_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned PORT_W   = 6,
  parameter logic [5:0]  RST_DIR  = 6'h2F,
  parameter logic [5:0]  RST_DATA = 6'h3F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BUS_W-1:0]  cpu_wdata,
  input  logic              cpu_we,
  output logic [BUS_W-1:0]  cpu_rdata,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  input  logic [PORT_W-1:0] pin_in,
  output logic [2:0]        region
);
  localparam int unsigned PAD_W = BUS_W - PORT_W;

  logic [PORT_W-1:0] dir_q, data_q, level;
  logic              sel_dir, sel_data;
  region_e           region_d;
  logic [BUS_W-1:0]  rdata_d;
  logic              unused_wbits;

  assign sel_dir      = (cpu_addr == ADDR_W'(0));
  assign sel_data     = (cpu_addr == ADDR_W'(1));
  assign unused_wbits = ^cpu_wdata[BUS_W-1:PORT_W];

  port_regfile #(
    .PORT_W(PORT_W), .RST_DIR(RST_DIR), .RST_DATA(RST_DATA)
  ) i_regs (
    .clk(clk), .rst(rst),
    .wr_dir(cpu_we && sel_dir), .wr_data(cpu_we && sel_data),
    .wdata(cpu_wdata[PORT_W-1:0]), .pin_in(pin_in),
    .dir_q(dir_q), .data_q(data_q), .level(level)
  );

  bank_decoder #(.ADDR_W(ADDR_W)) i_dec (
    .cfg(level[CFG_W-1:0]), .addr(cpu_addr), .we(cpu_we), .region(region_d)
  );

  always_comb begin
    rdata_d = '0;
    if (sel_dir)       rdata_d = {{PAD_W{1'b0}}, dir_q};
    else if (sel_data) rdata_d = {{PAD_W{1'b0}}, level};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      region    <= RGN_RAM;
    end else begin
      cpu_rdata <= rdata_d;
      region    <= region_d;
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/cpu_port_banker_chk.sv
module cpu_port_banker_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned PORT_W  = 6,
  parameter logic [5:0]  RST_DIR = 6'h2F
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [BUS_W-1:0]  cpu_wdata,
  input logic              cpu_we,
  input logic [BUS_W-1:0]  cpu_rdata,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] pin_in,
  input logic [2:0]        region
);
  logic unused_chk;
  assign unused_chk = ^{cpu_rdata, pin_in};

  AST_RESET_DIR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pin_oe == RST_DIR[PORT_W-1:0]); // R1
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == ADDR_W'(0)) |=> pin_oe == $past(cpu_wdata[PORT_W-1:0])); // R2
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr == ADDR_W'(1)) |=> pin_out == $past(cpu_wdata[PORT_W-1:0])); // R3
  AST_BASIC_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (region == 3'd1) |-> $past(cpu_addr[ADDR_W-1 -: 3]) == 3'b101); // R6
  AST_KERNAL_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (region == 3'd2) |-> $past(cpu_addr[ADDR_W-1 -: 3]) == 3'b111); // R7
  AST_PORT_REGION: assert property (@(posedge clk) disable iff (rst || $past(rst))
    ($past(cpu_addr[ADDR_W-1:1]) == '0) |-> region == 3'd5); // R9
  AST_WRITE_NO_ROM: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $past(cpu_we) |-> !(region inside {3'd1, 3'd2, 3'd3})); // R10
endmodule

bind cpu_port_banker cpu_port_banker_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .PORT_W(PORT_W), .RST_DIR(RST_DIR)
) i_chk (.*);

// File: tb/test_cpu_port_banker.sv
module test_cpu_port_banker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [5:0]  pin_out, pin_oe;
  logic [5:0]  pin_in = 6'h3F;
  logic [2:0]  region;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] m_dir = 6'h2F;
  logic [5:0] m_dat = 6'h3F;

  always #10 clk = ~clk;

  cpu_port_banker i_cpu_port_banker (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, sample at the next negedge.
  task automatic access(input logic [15:0] a, input logic [7:0] d, input logic w);
    cpu_addr = a; cpu_wdata = d; cpu_we = w;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  function automatic logic [5:0] lvl();
    return (m_dat & m_dir) | (pin_in & ~m_dir);
  endfunction

  function automatic int exp_region(input logic [15:0] a, input logic w, input logic [2:0] c);
    int r;
    logic lo, hi, cs;
    lo = c[0]; hi = c[1]; cs = c[2];
    if (a < 2) r = 5;
    else if (a >= 16'hA000 && a <= 16'hBFFF) r = (lo && hi) ? 1 : 0;
    else if (a >= 16'hE000) r = hi ? 2 : 0;
    else if (a >= 16'hD000 && a <= 16'hDFFF) r = (!lo && !hi) ? 0 : (cs ? 4 : 3);
    else r = 0;
    if (w && (r == 1 || r == 2 || r == 3)) r = 0;
    return r;
  endfunction

  initial begin
    logic [15:0] probes [13];
    probes = '{16'h0000, 16'h0001, 16'h0002, 16'h0400, 16'h9FFF, 16'hA000,
               16'hBFFF, 16'hC000, 16'hCFFF, 16'hD000, 16'hDFFF, 16'hE000, 16'hFFFF};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pin_oe", pin_oe, 'h2F);
    check("R1 pin_out", pin_out, 'h3F);
    check("R1 rdata", cpu_rdata, 0);
    check("R1 region", region, 0);

    // R11 normal map
    access(16'h0001, 8'h37, 1'b1); m_dat = 6'h37;
    check("R3 pin_out", pin_out, 'h37);
    access(16'hA123, 8'h00, 1'b0); check("R11 basic", region, 1);
    access(16'hF000, 8'h00, 1'b0); check("R11 kernal", region, 2);
    access(16'hD400, 8'h00, 1'b0); check("R11 io", region, 4);

    // R2 direction write and readback, upper bits dropped
    access(16'h0000, 8'hC5, 1'b1); m_dir = 6'h05;
    check("R2 pin_oe", pin_oe, 'h05);
    access(16'h0000, 8'h00, 1'b0); check("R2 readback", cpu_rdata, 'h05);
    // R4 mixed readback and zero elsewhere
    for (int p = 0; p < 64; p += 7) begin
      pin_in = 6'(p);
      access(16'h0001, 8'h00, 1'b0);
      check("R4 mixed read", cpu_rdata, {2'b00, lvl()});
    end
    access(16'h0002, 8'h00, 1'b0); check("R4 other addr", cpu_rdata, 0);
    access(16'hD000, 8'h00, 1'b0); check("R4 io addr reads 0", cpu_rdata, 0);

    // Sweep: mode 0 drives config from data bits, mode 1 from input pins (R5)
    for (int mode = 0; mode < 2; mode++) begin
      for (int c = 0; c < 8; c++) begin
        if (mode == 0) begin
          pin_in = 6'h00;
          access(16'h0000, 8'h2F, 1'b1); m_dir = 6'h2F;
          access(16'h0001, 8'(c), 1'b1); m_dat = 6'(c);
        end else begin
          pin_in = 6'(c) | 6'h38;
          access(16'h0001, 8'h07 ^ 8'(c), 1'b1); m_dat = 6'h07 ^ 6'(c);
          access(16'h0000, 8'h28, 1'b1); m_dir = 6'h28;
        end
        check("R2 dir sweep", pin_oe, m_dir);
        access(16'h0001, 8'h00, 1'b0);
        check("R5 level readback", cpu_rdata, {2'b00, lvl()});
        foreach (probes[i]) begin
          for (int w = 0; w < 2; w++) begin
            if (probes[i] < 2 && w == 1) continue;
            access(probes[i], 8'h00, 1'(w));
            // R6 R7 R8 R9 R10 decode table
            check($sformatf("R8 decode a=%h w=%0d cfg=%0d", probes[i], w, c),
                  region, exp_region(probes[i], 1'(w), lvl()[2:0]));
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule